// File: doc/BRIEF.md
# Glitch-Free Clock Output Enable Gate

This block sits between the per-channel clock dividers of a multi-output clock generator and the output pads. For each of `N_CH` channels it decides, from a shared active-low enable pin and a set of per-channel control bits, whether the channel clock is passed to the pad. When the clock is not passed, the block holds the pad at a chosen resting state. The control bits are a pin-ignore mask, a software disable, a power-down, an output invert and a 2-bit resting-state mode. The block produces a registered pad level and a pad drive-enable for each channel. A driver that is not enabled leaves the pad in high impedance.

All logic runs on one fast core clock. Each channel clock arrives as a level that changes on core clock edges. The enable pin may change at any time, so it is first passed through a synchroniser. A channel only switches between passing and resting at a leading edge of its own output clock, which is the channel clock after any inversion. As a result, an enable starts with a complete high phase and a disable happens only after a complete low phase. Neither direction can emit a runt pulse.

Top module: `clkout_enable_gate`

## Requirements
- R1: While `rst` is high, every `clk_out` bit and every `drive_en` bit is 0.
- R2: The enable pin `oe_pin_n` is active low and passes through `SYNC_STAGES` flip-flops before use. While a channel is running, `clk_out` equals the channel's output clock as sampled at the previous core clock edge.
- R3: If a channel's `pin_ignore` bit is 1, the enable pin has no effect on that channel. If the bit is 0, the pin gates the channel.
- R4: If a channel's `sw_disable` bit is 1, the channel stops. If the bit is 0, the pin path (or the ignore bit) decides.
- R5: The 2-bit mode field of a channel, at bits [2i+1:2i] of `dis_mode`, sets its resting state. Code 00 drives the pad low, 01 drives it high, and 10 leaves the pad undriven (`drive_en`=0).
- R6: Mode code 11 keeps the channel running whatever the pin and `sw_disable` are. Only power-down stops it.
- R7: Starting or stopping a channel takes effect only at a leading (0 to 1) edge of its output clock. No high or low phase on a driven output is ever shorter than the channel's half period.
- R8: If a channel's `invert` bit is 1, its output clock is the inverted channel clock. R7's leading edge then refers to this inverted clock.
- R9: When a channel's `power_down` bit is 1, its `clk_out` and `drive_en` are 0 after the next core clock edge. After power-down is released, the channel waits for a leading edge before it runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin_n | input | 1 | Shared output-enable pin, active low, asynchronous |
| src_clk | input | N_CH | Channel clock levels, synchronous to `clk` |
| pin_ignore | input | N_CH | 1: channel ignores the enable pin |
| sw_disable | input | N_CH | 1: channel stopped by software |
| power_down | input | N_CH | 1: channel off, pad undriven and low |
| invert | input | N_CH | 1: output clock is the inverted channel clock |
| dis_mode | input | 2*N_CH | Resting-state code per channel, 2 bits each |
| clk_out | output | N_CH | Registered pad level per channel |
| drive_en | output | N_CH | Pad driver enable per channel |

## Verification
The bench builds the gate with its defaults: eight channels and a two-stage pin synchroniser. Each channel gets a different half period, from 2 to 9 core cycles, so a single pin change lands at a different point in every channel's clock phase. Alternate channels run inverted, which brings both the non-inverted and the inverted leading-edge rules into play in the same run. With every resting mode assigned to some channel, the long random stretch can reach mid-phase start and stop requests in every mode. Each of these would produce a runt if the gate switched outside a leading edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        PARK_LOW   = 2'b00,
        PARK_HIGH  = 2'b01,
        PARK_HIZ   = 2'b10,
        PARK_NEVER = 2'b11
    } park_mode_e;

    typedef struct packed {
        logic       pin_ignore;
        logic       sw_disable;
        logic       power_down;
        logic       invert;
        park_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic level;
        logic drive;
    } chan_out_t;

    function automatic logic park_level(input park_mode_e m);
        return (m == PARK_HIGH);
    endfunction

    function automatic logic park_drive(input park_mode_e m);
        return (m != PARK_HIZ);
    endfunction

endpackage

// File: rtl/oeg_pin_sync.sv
module oeg_pin_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/oeg_request.sv
module oeg_request
    import clkgate_pkg::*;
(
    input  chan_cfg_t cfg,
    input  logic      pin_n_sync,
    output logic      want_on
);
    logic pin_allows;

    always_comb begin
        pin_allows = cfg.pin_ignore | ~pin_n_sync;
        if (cfg.power_down)              want_on = 1'b0;
        else if (cfg.mode == PARK_NEVER) want_on = 1'b1;
        else                             want_on = ~cfg.sw_disable & pin_allows;
    end
endmodule

// File: rtl/oeg_chan_gate.sv
module oeg_chan_gate
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       src_lvl,
    input  logic       want_on,
    input  logic       pdn,
    input  logic       invert,
    input  park_mode_e mode,
    output chan_out_t  q
);
    logic      p;
    logic      p_prev;
    logic      lead;
    logic      run_q;
    logic      run_nxt;
    chan_out_t q_nxt;

    assign p    = src_lvl ^ invert;
    assign lead = p & ~p_prev;

    always_comb begin
        if (pdn)       run_nxt = 1'b0;
        else if (lead) run_nxt = want_on;
        else           run_nxt = run_q;

        if (pdn) begin
            q_nxt.level = 1'b0;
            q_nxt.drive = 1'b0;
        end else begin
            q_nxt.level = run_nxt ? p : park_level(mode);
            q_nxt.drive = run_nxt | park_drive(mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_prev <= 1'b1;
            run_q  <= 1'b0;
            q      <= '0;
        end else begin
            p_prev <= p;
            run_q  <= run_nxt;
            q      <= q_nxt;
        end
    end

    // R9
    pdn_off_chk: assert property (@(posedge clk) disable iff (rst)
        pdn |=> (!q.level && !q.drive && !run_q));

    // R5
    park_state_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(pdn) && !run_q) |->
        (q.level == park_level($past(mode)) && q.drive == park_drive($past(mode))));

    // R8
    run_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && run_q) |-> (q.level == $past(p) && q.drive));

    // R7
    switch_at_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(pdn) && !$past(lead)) |-> (run_q == $past(run_q)));

    // R4
    lead_takes_req_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(pdn) && $past(lead)) |-> (run_q == $past(want_on)));

endmodule

// File: rtl/clkout_enable_gate.sv
module clkout_enable_gate
    import clkgate_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_pin_n,
    input  logic [N_CH-1:0]   src_clk,
    input  logic [N_CH-1:0]   pin_ignore,
    input  logic [N_CH-1:0]   sw_disable,
    input  logic [N_CH-1:0]   power_down,
    input  logic [N_CH-1:0]   invert,
    input  logic [2*N_CH-1:0] dis_mode,
    output logic [N_CH-1:0]   clk_out,
    output logic [N_CH-1:0]   drive_en
);
    localparam int MODE_W = 2;

    logic pin_n_sync;

    oeg_pin_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_pin_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(oe_pin_n),
        .q_sync (pin_n_sync)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        chan_cfg_t cfg;
        chan_out_t qo;
        logic      want;

        assign cfg.pin_ignore = pin_ignore[i];
        assign cfg.sw_disable = sw_disable[i];
        assign cfg.power_down = power_down[i];
        assign cfg.invert     = invert[i];
        assign cfg.mode       = park_mode_e'(dis_mode[MODE_W*i +: MODE_W]);

        oeg_request u_req (
            .cfg       (cfg),
            .pin_n_sync(pin_n_sync),
            .want_on   (want)
        );

        oeg_chan_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .src_lvl(src_clk[i]),
            .want_on(want),
            .pdn    (cfg.power_down),
            .invert (cfg.invert),
            .mode   (cfg.mode),
            .q      (qo)
        );

        assign clk_out[i]  = qo.level;
        assign drive_en[i] = qo.drive;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (clk_out == '0 && drive_en == '0));

endmodule

// File: tb/clkout_enable_gate_tb.sv
module clkout_enable_gate_tb;
    localparam int  N      = 8;
    localparam int  SYNC   = 2;
    localparam time CLK_PERIOD = 10ns;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           oe_pin_n = 1'b1;
    logic [N-1:0]   src_clk = '0;
    logic [N-1:0]   pin_ignore = '0;
    logic [N-1:0]   sw_disable = '0;
    logic [N-1:0]   power_down = '0;
    logic [N-1:0]   invert = '0;
    logic [2*N-1:0] dis_mode = '0;
    logic [N-1:0]   clk_out;
    logic [N-1:0]   drive_en;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R2";
    bit    mon_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_enable_gate #(.N_CH(N), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .oe_pin_n(oe_pin_n), .src_clk(src_clk),
        .pin_ignore(pin_ignore), .sw_disable(sw_disable), .power_down(power_down),
        .invert(invert), .dis_mode(dis_mode), .clk_out(clk_out), .drive_en(drive_en)
    );

    function automatic int half_of(input int ch);
        return ch + 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // channel clock sources, each with its own half period
    int src_cnt [N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (src_cnt[i] >= half_of(i) - 1) begin
                src_clk[i] = ~src_clk[i];
                src_cnt[i] = 0;
            end else begin
                src_cnt[i]++;
            end
        end
    end

    // behavioural reference, evaluated at each rising edge
    bit [N-1:0] m_run, m_out, m_oe, m_prev, src_at_pos;
    bit         pinq [$];
    always @(posedge clk) begin
        src_at_pos = src_clk;
        if (rst) begin
            m_run = '0; m_out = '0; m_oe = '0; m_prev = '1;
            pinq.delete();
            for (int k = 0; k < SYNC; k++) pinq.push_back(1'b1);
        end else begin
            bit pin_eff;
            pin_eff = pinq[0];
            for (int i = 0; i < N; i++) begin
                bit p, rise, req;
                int md;
                md   = dis_mode[2*i +: 2];
                p    = src_clk[i] ^ invert[i];
                rise = p && !m_prev[i];
                m_prev[i] = p;
                req  = (md == 3) || (!sw_disable[i] && (pin_ignore[i] || !pin_eff));
                if (power_down[i]) begin
                    m_run[i] = 0; m_out[i] = 0; m_oe[i] = 0;
                end else begin
                    if (rise) m_run[i] = req;
                    m_out[i] = m_run[i] ? p : (md == 1);
                    m_oe[i]  = m_run[i] || (md != 2);
                end
            end
            pinq.push_back(oe_pin_n);
            void'(pinq.pop_front());
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(clk_out == m_out, cur_tag, "clk_out vs model", clk_out, m_out);
            chk(drive_en == m_oe, cur_tag, "drive_en vs model", drive_en, m_oe);
        end
    end

    // phase-width monitor (R7)
    int phase_len [N];
    bit phase_seen[N];
    bit last_lvl  [N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!mon_on || rst || !drive_en[i] || power_down[i]) begin
                phase_seen[i] = 0;
                phase_len[i]  = 0;
                last_lvl[i]   = clk_out[i];
            end else if (clk_out[i] != last_lvl[i]) begin
                if (phase_seen[i])
                    chk(phase_len[i] >= half_of(i), "R7", $sformatf("phase width ch%0d", i),
                        phase_len[i], half_of(i));
                phase_seen[i] = 1;
                phase_len[i]  = 1;
                last_lvl[i]   = clk_out[i];
            end else begin
                phase_len[i]++;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_toggles(input int ch, input int n, output int t);
        logic prev;
        t = 0;
        @(negedge clk);
        prev = clk_out[ch];
        repeat (n) begin
            @(negedge clk);
            if (clk_out[ch] != prev) t++;
            prev = clk_out[ch];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, t1, hi;
        cycles(4);
        // R1: reset state
        chk(clk_out == '0, "R1", "clk_out in reset", clk_out, 0);
        chk(drive_en == '0, "R1", "drive_en in reset", drive_en, 0);
        rst = 1'b0;

        // R2 / R5: pin high, all parked low and driven
        cur_tag = "R2";
        cycles(30);
        chk(clk_out == '0, "R5", "parked low level", clk_out, 0);
        chk(drive_en == '1, "R5", "parked low drive", drive_en, 8'hFF);

        // R7: enable gives a full first high phase on ch7
        oe_pin_n = 1'b0;
        cur_tag = "R7";
        while (clk_out[7] == 1'b0) @(negedge clk);
        hi = 0;
        while (clk_out[7] == 1'b1) begin hi++; @(negedge clk); end
        chk(hi == half_of(7), "R7", "first high phase ch7", hi, half_of(7));

        cur_tag = "R2";
        count_toggles(0, 30, t0);
        chk(t0 > 5, "R2", "ch0 toggles with pin low", t0, 6);

        // R3: pin high, even channels ignore pin
        oe_pin_n = 1'b1;
        pin_ignore = 8'h55;
        cur_tag = "R3";
        cycles(40);
        count_toggles(0, 30, t0);
        count_toggles(1, 30, t1);
        chk(t0 > 5, "R3", "ignoring ch0 keeps running", t0, 6);
        chk(t1 == 0 && clk_out[1] == 0, "R3", "ch1 stopped by pin", t1, 0);

        // R4: software disable on ch0 and ch2
        sw_disable = 8'h05;
        cur_tag = "R4";
        cycles(40);
        count_toggles(2, 30, t0);
        chk(t0 == 0 && clk_out[2] == 0, "R4", "ch2 software disabled", t0, 0);
        count_toggles(4, 30, t1);
        chk(t1 > 3, "R4", "ch4 still running", t1, 4);

        // R5 / R6: resting modes, mode 11 overrides pin and sw
        pin_ignore = '0;
        sw_disable = 8'h88;
        dis_mode = {2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
        cur_tag = "R5";
        cycles(40);
        chk(drive_en == 8'hBB, "R5", "drive per mode", drive_en, 8'hBB);
        chk((clk_out & 8'h77) == 8'h22, "R5", "park levels", clk_out & 8'h77, 8'h22);
        count_toggles(3, 30, t0);
        chk(t0 > 3, "R6", "never-disable ch3 runs despite pin and sw", t0, 4);

        // R9: power-down takes effect after one edge
        power_down = '1;
        cur_tag = "R9";
        @(negedge clk);
        chk(clk_out == '0 && drive_en == '0, "R9", "power-down outputs", {clk_out, drive_en}, 0);

        // R8: inverted odd channels
        invert = 8'hAA;
        dis_mode = '0;
        sw_disable = '0;
        oe_pin_n = 1'b0;
        cycles(3);
        power_down = '0;
        cur_tag = "R8";
        cycles(40);
        begin
            bit ok8 = 1;
            repeat (20) begin
                @(negedge clk);
                if (clk_out[1] != ~src_at_pos[1] || clk_out[0] != src_at_pos[0]) ok8 = 0;
            end
            chk(ok8, "R8", "ch1 inverted, ch0 direct", clk_out[1:0], {~src_at_pos[1], src_at_pos[0]});
        end

        // R7: random pin and control changes, phase monitor active
        dis_mode = {2'b00, 2'b01, 2'b11, 2'b00, 2'b01, 2'b00, 2'b01, 2'b10};
        cycles(2);
        cur_tag = "R7";
        mon_on = 1;
        repeat (4000) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) oe_pin_n = ~oe_pin_n;
            if ($urandom_range(0, 31) == 0) sw_disable[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 63) == 0) pin_ignore[$urandom_range(0, N-1)] ^= 1'b1;
        end
        mon_on = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule